// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight-bit condition and mode byte of a small accumulator-style processor core. Six bits are real storage: negative, overflow, decimal, interrupt mask, zero and carry. Bit 5 is tied to one. Bit 4, the break marker, is produced only when the byte is read. Each cycle the block takes update requests from several sources. It applies them by a fixed priority and presents the new byte on the next clock edge.

The execution unit reports a result class and result values. The sequencer issues explicit set and clear commands, status restore from a popped stack byte, and interrupt entry. An asynchronous active-low pin can raise the overflow flag. A second output gives the byte to be written to the stack. In that byte the break bit is cleared only for a pure hardware interrupt entry. The ALU datapath, the stack memory and the vector selection stay outside and connect through plain ports.

Top module: `psr_status_reg`

## Requirements
- R1: After reset `status_out` reads 0x34: I=1, bit 5=1, B=1, and N, V, D, Z, C all 0.
- R2: The bit layout of `status_out` is N=7, V=6, constant 1 at 5, B=4, D=3, I=2, Z=1, C=0. Bits 5 and 4 read as 1 at all times.
- R3: With `op_sel`=1 (register load), N takes `res_val[7]` and Z is set exactly when `res_val` is zero. All other flags hold. `op_sel`=0 and 5..7 change nothing.
- R4: With `op_sel`=2 (add/subtract), N and Z follow `res_val` as in R3, C takes `alu_c` (the inverted borrow on subtraction) and V takes `alu_v`.
- R5: With `op_sel`=3 (shift, rotate or compare), N, Z and C update as in R4 while V, D and I hold.
- R6: With `op_sel`=4 (bit test), N takes `opnd_val[7]`, V takes `opnd_val[6]` and Z is set exactly when `res_val` (the masked value) is zero. C holds.
- R7: `cmd_sel` encodes 1=clear C, 2=set C, 3=clear I, 4=set I, 5=clear D, 6=set D, 7=clear V, 0=none. No command value sets V.
- R8: `rest_en` loads N, V, D, I, Z, C from bits 7, 6, 3, 2, 1, 0 of `rest_val`. Bits 5 and 4 of `rest_val` have no effect.
- R9: `int_take` sets I, visible one cycle later.
- R10: `push_byte` equals `status_out` except bit 4. That bit is 0 only while `int_hw`=1 and `brk_act`=0, so a break in progress keeps B=1 even during a hardware interrupt entry.
- R11: A high-to-low transition of `sov_n`, first sampled at edge k, sets V from edge k+2. A level held low sets V only once.
- R12: When several requests target one flag in a cycle, the priority is restore, then command, then `op_sel` result, then the `sov_n` edge. For I the priority is restore, then `int_take`, then command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 3 | Result class from the execution unit |
| res_val | input | 8 | Result or masked value for N/Z |
| opnd_val | input | 8 | Bit-test operand |
| alu_c | input | 1 | ALU carry out |
| alu_v | input | 1 | ALU signed overflow |
| cmd_sel | input | 3 | Explicit flag command |
| rest_en | input | 1 | Restore status from stack byte |
| rest_val | input | 8 | Popped stack byte |
| int_take | input | 1 | Interrupt entry this cycle |
| int_hw | input | 1 | Push belongs to a hardware interrupt entry |
| brk_act | input | 1 | A software break is in progress |
| sov_n | input | 1 | Asynchronous active-low set-overflow pin |
| status_out | output | 8 | Current status byte |
| push_byte | output | 8 | Status byte formatted for the stack |

## Verification
Every request on the update ports shows in `status_out` one clock after the edge that samples it. `push_byte` is combinational: it reflects the flags after that edge together with the push-kind inputs still held. The `sov_n` pin is the exception. Its effect appears two edges after the edge that first samples it low. The reference model therefore keeps a countdown started by the falling edge and applies the V set at its lowest priority when the countdown expires. Each stimulus cycle queues one expected pair of bytes, and the monitor compares them shortly after the following rising edge.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int unsigned PSR_W = 8;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_ARITH = 3'd2,
    OP_NZC   = 3'd3,
    OP_BTEST = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_CLRC = 3'd1,
    CMD_SETC = 3'd2,
    CMD_CLRI = 3'd3,
    CMD_SETI = 3'd4,
    CMD_CLRD = 3'd5,
    CMD_SETD = 3'd6,
    CMD_CLRV = 3'd7
  } cmd_e;

  typedef struct packed {
    logic n;
    logic v;
    logic d;
    logic i;
    logic z;
    logic c;
  } flags_t;

  localparam flags_t FLAGS_RST = '{n: 1'b0, v: 1'b0, d: 1'b0, i: 1'b1, z: 1'b0, c: 1'b0};

  // Zero detect of a result byte.
  function automatic logic is_zero(input logic [PSR_W-1:0] val);
    return (val == '0);
  endfunction

  // Sign of a result byte.
  function automatic logic sign_of(input logic [PSR_W-1:0] val);
    return val[PSR_W-1];
  endfunction

  // Assemble the architectural byte; brk selects the value of bit 4.
  function automatic logic [PSR_W-1:0] pack_byte(input flags_t f, input logic brk);
    return {f.n, f.v, 1'b1, brk, f.d, f.i, f.z, f.c};
  endfunction

  // Pull stored flags out of a byte, ignoring bits 5 and 4.
  function automatic flags_t unpack_byte(input logic [PSR_W-1:0] val);
    flags_t f;
    f.n = val[7];
    f.v = val[6];
    f.d = val[3];
    f.i = val[2];
    f.z = val[1];
    f.c = val[0];
    return f;
  endfunction

endpackage

// File: rtl/psr_sov_sync.sv
module psr_sov_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  localparam int unsigned CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  generate
    for (genvar g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= pin_n;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  // Older sample high, newer synchronised sample low.
  assign fall = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];
endmodule

// File: rtl/psr_next.sv
module psr_next
  import psr_pkg::*;
(
  input  flags_t           cur,
  input  logic [2:0]       op_sel,
  input  logic [PSR_W-1:0] res_val,
  input  logic [PSR_W-1:0] opnd_val,
  input  logic             alu_c,
  input  logic             alu_v,
  input  logic [2:0]       cmd_sel,
  input  logic             rest_en,
  input  logic [PSR_W-1:0] rest_val,
  input  logic             int_take,
  input  logic             sov_fall,
  output flags_t           nxt
);
  // Later assignments win: lowest priority source is applied first.
  always_comb begin
    nxt = cur;

    if (sov_fall) nxt.v = 1'b1;

    unique case (op_sel)
      OP_LOAD: begin
        nxt.n = sign_of(res_val);
        nxt.z = is_zero(res_val);
      end
      OP_ARITH: begin
        nxt.n = sign_of(res_val);
        nxt.z = is_zero(res_val);
        nxt.c = alu_c;
        nxt.v = alu_v;
      end
      OP_NZC: begin
        nxt.n = sign_of(res_val);
        nxt.z = is_zero(res_val);
        nxt.c = alu_c;
      end
      OP_BTEST: begin
        nxt.n = opnd_val[7];
        nxt.v = opnd_val[6];
        nxt.z = is_zero(res_val);
      end
      default: ;
    endcase

    unique case (cmd_sel)
      CMD_CLRC: nxt.c = 1'b0;
      CMD_SETC: nxt.c = 1'b1;
      CMD_CLRI: nxt.i = 1'b0;
      CMD_SETI: nxt.i = 1'b1;
      CMD_CLRD: nxt.d = 1'b0;
      CMD_SETD: nxt.d = 1'b1;
      CMD_CLRV: nxt.v = 1'b0;
      default: ;
    endcase

    if (int_take) nxt.i = 1'b1;

    if (rest_en) nxt = unpack_byte(rest_val);
  end
endmodule

// File: rtl/psr_push_fmt.sv
module psr_push_fmt
  import psr_pkg::*;
(
  input  flags_t           flags,
  input  logic             int_hw,
  input  logic             brk_act,
  output logic [PSR_W-1:0] push_byte,
  output logic             hw_push
);
  // Only a pure hardware entry pushes a cleared break bit.
  assign hw_push   = int_hw & ~brk_act;
  assign push_byte = pack_byte(flags, ~hw_push);
endmodule

// File: rtl/psr_status_reg.sv
module psr_status_reg
  import psr_pkg::*;
#(
  parameter int unsigned SOV_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] op_sel,
  input  logic [7:0] res_val,
  input  logic [7:0] opnd_val,
  input  logic       alu_c,
  input  logic       alu_v,
  input  logic [2:0] cmd_sel,
  input  logic       rest_en,
  input  logic [7:0] rest_val,
  input  logic       int_take,
  input  logic       int_hw,
  input  logic       brk_act,
  input  logic       sov_n,
  output logic [7:0] status_out,
  output logic [7:0] push_byte
);
  flags_t flags_q;
  flags_t flags_d;
  logic   sov_fall;
  logic   hw_push;

  psr_sov_sync #(.STAGES(SOV_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (sov_n),
    .fall  (sov_fall)
  );

  psr_next u_next (
    .cur      (flags_q),
    .op_sel   (op_sel),
    .res_val  (res_val),
    .opnd_val (opnd_val),
    .alu_c    (alu_c),
    .alu_v    (alu_v),
    .cmd_sel  (cmd_sel),
    .rest_en  (rest_en),
    .rest_val (rest_val),
    .int_take (int_take),
    .sov_fall (sov_fall),
    .nxt      (flags_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= FLAGS_RST;
    else        flags_q <= flags_d;
  end

  psr_push_fmt u_push (
    .flags     (flags_q),
    .int_hw    (int_hw),
    .brk_act   (brk_act),
    .push_byte (push_byte),
    .hw_push   (hw_push)
  );

  assign status_out = pack_byte(flags_q, 1'b1);
endmodule

// File: rtl/psr_status_chk.sv
module psr_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] op_sel,
  input logic [7:0] res_val,
  input logic [7:0] opnd_val,
  input logic [2:0] cmd_sel,
  input logic       rest_en,
  input logic [7:0] rest_val,
  input logic       int_take,
  input logic       int_hw,
  input logic       brk_act,
  input logic       sov_fall,
  input logic       hw_push,
  input logic [7:0] status_out,
  input logic [7:0] push_byte
);
  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    status_out[5:4] == 2'b11);

  a_r3_load_nz: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd1 && !rest_en) |=>
      (status_out[7] == $past(res_val[7]) && status_out[1] == ($past(res_val) == 8'h00)));

  a_r6_btest_v: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd4 && !rest_en && cmd_sel != 3'd7) |=> status_out[6] == $past(opnd_val[6]));

  a_r7_clrv: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sel == 3'd7 && !rest_en) |=> !status_out[6]);

  a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
    rest_en |=> (status_out[7:6] == $past(rest_val[7:6]) &&
                 status_out[3:0] == $past(rest_val[3:0])));

  a_r9_int_sets_i: assert property (@(posedge clk) disable iff (!rst_n)
    (int_take && !rest_en) |=> status_out[2]);

  a_r10_push_b: assert property (@(posedge clk) disable iff (!rst_n)
    push_byte[4] == !(int_hw && !brk_act));

  a_r10_push_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (push_byte[7:5] == status_out[7:5] && push_byte[3:0] == status_out[3:0]));

  a_r11_sov_sets_v: assert property (@(posedge clk) disable iff (!rst_n)
    (sov_fall && !rest_en && cmd_sel != 3'd7 && op_sel != 3'd2 && op_sel != 3'd4)
      |=> status_out[6]);

  a_r12_hw_push_wire: assert property (@(posedge clk) disable iff (!rst_n)
    hw_push |-> !push_byte[4]);
endmodule

bind psr_status_reg psr_status_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_sel     (op_sel),
  .res_val    (res_val),
  .opnd_val   (opnd_val),
  .cmd_sel    (cmd_sel),
  .rest_en    (rest_en),
  .rest_val   (rest_val),
  .int_take   (int_take),
  .int_hw     (int_hw),
  .brk_act    (brk_act),
  .sov_fall   (sov_fall),
  .hw_push    (hw_push),
  .status_out (status_out),
  .push_byte  (push_byte)
);

// File: tb/test_psr_status_reg.sv
module test_psr_status_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op_sel;
  logic [7:0] res_val, opnd_val, rest_val;
  logic       alu_c, alu_v, rest_en, int_take, int_hw, brk_act, sov_n;
  logic [2:0] cmd_sel;
  logic [7:0] status_out, push_byte;

  always #5 clk = ~clk;

  psr_status_reg i_psr_status_reg (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .res_val(res_val),
    .opnd_val(opnd_val), .alu_c(alu_c), .alu_v(alu_v), .cmd_sel(cmd_sel),
    .rest_en(rest_en), .rest_val(rest_val), .int_take(int_take),
    .int_hw(int_hw), .brk_act(brk_act), .sov_n(sov_n),
    .status_out(status_out), .push_byte(push_byte)
  );

  typedef struct {
    logic [7:0] st;
    logic [7:0] pb;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // Reference flags
  logic mn, mv, md, mi, mz, mc;
  logic sov_prev;
  int   sov_cnt;

  function automatic logic [7:0] model_byte(input logic b);
    return {mn, mv, 1'b1, b, md, mi, mz, mc};
  endfunction

  // Driver: apply one cycle of stimulus and queue the expected bytes.
  task automatic step(input logic [2:0] op, input logic [7:0] res, input logic [7:0] opnd,
                      input logic c, input logic v, input logic [2:0] cmd,
                      input logic ren, input logic [7:0] rval, input logic it,
                      input logic hw, input logic brk, input logic sn, input string tag);
    exp_t e;
    logic sov_hit;
    @(negedge clk);
    op_sel = op; res_val = res; opnd_val = opnd; alu_c = c; alu_v = v;
    cmd_sel = cmd; rest_en = ren; rest_val = rval; int_take = it;
    int_hw = hw; brk_act = brk; sov_n = sn;
    sov_hit = 1'b0;
    if (sov_cnt > 0) begin
      sov_cnt--;
      if (sov_cnt == 0) sov_hit = 1'b1;
    end
    if (sov_prev && !sn) sov_cnt = 2;
    sov_prev = sn;
    // R12 lowest priority first: pin edge (R11)
    if (sov_hit) mv = 1'b1;
    // R3..R6 result classes
    if (op == 3'd1 || op == 3'd2 || op == 3'd3) begin
      mn = res[7]; mz = (res == 8'h00);
    end
    if (op == 3'd2 || op == 3'd3) mc = c;
    if (op == 3'd2) mv = v;
    if (op == 3'd4) begin
      mn = opnd[7]; mv = opnd[6]; mz = (res == 8'h00);
    end
    // R7 commands
    if (cmd == 3'd1) mc = 1'b0;
    if (cmd == 3'd2) mc = 1'b1;
    if (cmd == 3'd3) mi = 1'b0;
    if (cmd == 3'd4) mi = 1'b1;
    if (cmd == 3'd5) md = 1'b0;
    if (cmd == 3'd6) md = 1'b1;
    if (cmd == 3'd7) mv = 1'b0;
    // R9
    if (it) mi = 1'b1;
    // R8
    if (ren) begin
      mn = rval[7]; mv = rval[6]; md = rval[3]; mi = rval[2]; mz = rval[1]; mc = rval[0];
    end
    e.st  = model_byte(1'b1);
    e.pb  = model_byte(!(hw && !brk));
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, sov_prev, tag);
  endtask

  // Monitor: compare shortly after each rising edge.
  always @(posedge clk) begin
    #2;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (status_out !== e.st) begin
        n_bad++;
        $display("FAIL %s status_out actual=%02h expected=%02h", e.tag, status_out, e.st);
      end
      n_cmp++;
      if (push_byte !== e.pb) begin
        n_bad++;
        $display("FAIL %s push_byte actual=%02h expected=%02h", e.tag, push_byte, e.pb);
      end
    end
  end

  initial begin
    rst_n = 1'b0; op_sel = 0; res_val = 0; opnd_val = 0; alu_c = 0; alu_v = 0;
    cmd_sel = 0; rest_en = 0; rest_val = 0; int_take = 0; int_hw = 0; brk_act = 0;
    sov_n = 1'b1; sov_prev = 1'b1; sov_cnt = 0;
    mn = 0; mv = 0; md = 0; mi = 1; mz = 0; mc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R2 reset value
    idle("R1 reset");
    // R3 load
    step(3'd1, 8'h80, 8'h00, 1'b1, 1'b1, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R3 load neg");
    step(3'd1, 8'h00, 8'h00, 1'b1, 1'b1, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R3 load zero");
    step(3'd6, 8'h00, 8'h00, 1'b1, 1'b1, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R3 unused op");
    // R4 arith: 123+45 overflows, no carry
    step(3'd2, 8'hA8, 8'h00, 1'b0, 1'b1, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R4 arith ovf");
    step(3'd2, 8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R4 arith carry zero");
    // R5 shift keeps V
    step(3'd3, 8'h40, 8'h00, 1'b0, 1'b1, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R5 shift");
    // R6 bit test
    step(3'd4, 8'h00, 8'hC0, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R6 btest");
    step(3'd4, 8'h01, 8'h3F, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R6 btest clear");
    // R7 commands, each one in turn
    for (int k = 1; k < 8; k++)
      step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'(k), 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R7 cmd");
    step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd6, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R7 set D");
    // R8 restore, bits 5/4 of byte ignored
    step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1, 8'hCB, 1'b0, 1'b0, 1'b0, 1'b1, "R8 restore");
    step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1, 8'h30, 1'b0, 1'b0, 1'b0, 1'b1, "R8 restore 5/4");
    // R9 interrupt entry with push kinds (R10)
    step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, "R9 R10 hw entry");
    step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, "R10 brk during hw");
    step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, "R10 sw push");
    // R11 set-overflow pin: V clear first
    step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd7, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R11 prep");
    step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R11 fall");
    idle("R11 wait");
    idle("R11 set");
    step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd7, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R11 clear held");
    repeat (4) idle("R11 held low once");
    // R12 priorities
    step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R12 pin high");
    step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R12 fall");
    idle("R12 wait");
    step(3'd2, 8'h01, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R12 alu over pin");
    step(3'd2, 8'h01, 8'h00, 1'b0, 1'b0, 3'd2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R12 cmd over alu");
    step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd1, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, "R12 restore over cmd");
    step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd3, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R12 int over cli");
    step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R12 restore over int");
    idle("R12 tail");
    @(posedge clk);
    #4;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule